// File: doc/BRIEF.md
# Converter Output Update Controller

This block sits between an 8-bit register bus and a 10-bit digital-to-analog converter. Software programs a control byte and writes a 10-bit value as two bytes. The block decides when that value becomes the code that drives the converter.

There are two update modes:

- **Direct mode.** The code is refreshed at the clock edge that accepts the high-byte write.
- **Auto mode.** The written value is only staged. It is copied to the converter code on a rising edge of one of eight trigger lines, selected by a 3-bit field.

Each trigger line owns a pending flag. The flag is raised by every rising edge of that line and cleared through a per-line clear input. A selected edge that arrives while its flag is still raised does not copy anything.

The low byte waits in a temporary register until the high byte is written, so both halves always move together. When the converter is disabled, the output code is forced to zero and no copy takes effect.

A three-state machine tracks the mode, and it changes state only on a control-register write:

| State | Meaning |
|---|---|
| `MODE_OFF` | Converter disabled |
| `MODE_DIRECT` | Copy on high-byte write |
| `MODE_AUTO` | Copy on selected trigger edge |

| Transition | Control write that causes it |
|---|---|
| `T_DISABLE` (any state to `MODE_OFF`) | Enable bit 0 |
| `T_GO_DIRECT` (any state to `MODE_DIRECT`) | Enable 1, auto bit 0 |
| `T_GO_AUTO` (any state to `MODE_AUTO`) | Enable 1, auto bit 1 |

Without a control write, every state holds.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `dac_code` is 0, and `dac_en` and `dac_oe` are 0.
- R2: The bus map is: address 0 control, address 1 low byte (reads back the staged low byte), address 2 high byte, address 3 reads 0. Control bit positions are 7 auto enable, 6:4 trigger select, 2 left adjust, 1 output enable, 0 converter enable. Bit 3 always reads 0, and the other bits read back as written.
- R3: `dac_en` follows control bit 0 and `dac_oe` follows control bit 1, from the edge that accepts the control write.
- R4: In direct mode with the converter enabled, a write to address 2 sets `dac_code` at the same clock edge from the written high byte and the staged low byte.
- R5: A write to address 1 alone never changes `dac_code`. The staged low byte moves to the holding pair only together with a high-byte write.
- R6: With left adjust 0 the code is {high[1:0], low[7:0]}. With left adjust 1 the code is {high[7:0], low[7:6]}.
- R7: In auto mode a high-byte write does not change `dac_code`. A 0-to-1 change of the selected trigger, seen between two consecutive clock samples, copies the holding pair at that edge. A level held high does not copy again.
- R8: Triggers other than the selected one, and any trigger while in direct mode, leave `dac_code` unchanged.
- R9: Each trigger's flag is set by its rising edge in every mode and cleared by a one-cycle pulse on its `flag_clr` bit. A selected edge arriving while its flag is set does not copy.
- R10: While control bit 0 is 0, `dac_code` is 0 and neither writes nor triggers change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| trig_in | input | 8 | Trigger source lines |
| flag_clr | input | 8 | Per-source flag clear pulses |
| dac_code | output | 10 | Code to the converter |
| dac_en | output | 1 | Converter enable |
| dac_oe | output | 1 | Converter output enable |

## Verification
A wrong mode state is visible on `dac_code` within one clock:

- A machine stuck in `MODE_DIRECT` lets a high-byte write through while auto mode is programmed.
- A machine stuck in `MODE_OFF` keeps the code at zero after enabling.

A stale or missing trigger flag shows at the next edge of the selected line, either as an update that should have been blocked or as one that never came. A broken staging register shows as a mixed code only at the following high-byte write.

The bench therefore compares the code against a behavioural model at every clock, so that each of these faults is reported in the cycle where it first appears.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CODE_W = 10;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_OE   = 1;
    localparam int unsigned BIT_LADJ = 2;
    localparam int unsigned BIT_RSVD = 3;
    localparam int unsigned SEL_LSB  = 4;
    localparam int unsigned BIT_ATE  = 7;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_DIRECT = 2'd1,
        MODE_AUTO   = 2'd2
    } dac_mode_e;

    // Pack two bytes into a converter code, right- or left-aligned.
    function automatic logic [CODE_W-1:0] pack_code(
        input logic              ladj,
        input logic [BYTE_W-1:0] hi,
        input logic [BYTE_W-1:0] lo
    );
        if (ladj) begin
            return {hi, lo[BYTE_W-1 -: 2]};
        end
        return {hi[1:0], lo};
    endfunction

endpackage

// File: rtl/dac_regfile.sv
module dac_regfile
    import dac_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] lo_stage_q,
    output logic [BYTE_W-1:0] hold_lo_q,
    output logic [BYTE_W-1:0] hold_hi_q,
    output logic              ctrl_wr,
    output logic              hi_wr,
    output logic [BYTE_W-1:0] bus_rdata
);

    logic lo_wr;

    assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
    assign lo_wr   = bus_we && (bus_addr == ADDR_LO);
    assign hi_wr   = bus_we && (bus_addr == ADDR_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            lo_stage_q <= '0;
            hold_lo_q  <= '0;
            hold_hi_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q           <= bus_wdata;
                ctrl_q[BIT_RSVD] <= 1'b0;
            end
            if (lo_wr) begin
                lo_stage_q <= bus_wdata;
            end
            if (hi_wr) begin
                hold_hi_q <= bus_wdata;
                hold_lo_q <= lo_stage_q;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_LO:   bus_rdata = lo_stage_q;
            ADDR_HI:   bus_rdata = hold_hi_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dac_trig_unit.sv
module dac_trig_unit #(
    parameter int unsigned NUM_TRIG = 8,
    localparam int unsigned SEL_W   = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [NUM_TRIG-1:0] flag_clr,
    input  logic [SEL_W-1:0]    sel,
    output logic [NUM_TRIG-1:0] rise,
    output logic [NUM_TRIG-1:0] flags,
    output logic                sel_fire
);

    logic [NUM_TRIG-1:0] trig_q;

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_src
        assign rise[i] = trig_in[i] && !trig_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                trig_q[i] <= 1'b0;
                flags[i]  <= 1'b0;
            end else begin
                trig_q[i] <= trig_in[i];
                flags[i]  <= (flags[i] && !flag_clr[i]) || rise[i];
            end
        end
    end

    // A selected edge counts only if its flag was clear before the edge.
    assign sel_fire = rise[sel] && !flags[sel];

endmodule

// File: rtl/dac_mode_fsm.sv
module dac_mode_fsm
    import dac_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic      new_en,
    input  logic      new_ate,
    input  logic      hi_wr,
    input  logic      sel_fire,
    output dac_mode_e mode_q,
    output logic      load_direct,
    output logic      load_hold,
    output logic      clear_code
);

    dac_mode_e mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Transitions T_DISABLE, T_GO_DIRECT, T_GO_AUTO on a control write.
    always_comb begin
        mode_d = mode_q;
        if (ctrl_wr) begin
            unique case ({new_en, new_ate})
                2'b10:   mode_d = MODE_DIRECT;
                2'b11:   mode_d = MODE_AUTO;
                default: mode_d = MODE_OFF;
            endcase
        end
    end

    always_comb begin
        load_direct = 1'b0;
        load_hold   = 1'b0;
        clear_code  = 1'b0;
        unique case (mode_q)
            MODE_DIRECT: load_direct = hi_wr;
            MODE_AUTO:   load_hold   = sel_fire;
            default:     clear_code  = 1'b1;
        endcase
    end

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int unsigned NUM_TRIG = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [1:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [NUM_TRIG-1:0] flag_clr,
    output logic [9:0]          dac_code,
    output logic                dac_en,
    output logic                dac_oe
);

    localparam int unsigned SEL_W = $clog2(NUM_TRIG);

    logic [BYTE_W-1:0]   ctrl_q;
    logic [BYTE_W-1:0]   lo_stage_q;
    logic [BYTE_W-1:0]   hold_lo_q;
    logic [BYTE_W-1:0]   hold_hi_q;
    logic                ctrl_wr;
    logic                hi_wr;
    logic [NUM_TRIG-1:0] rise_vec;
    logic [NUM_TRIG-1:0] flag_vec;
    logic                sel_fire;
    dac_mode_e           mode;
    logic                load_direct;
    logic                load_hold;
    logic                clear_code;
    logic [CODE_W-1:0]   code_q;

    dac_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ctrl_q     (ctrl_q),
        .lo_stage_q (lo_stage_q),
        .hold_lo_q  (hold_lo_q),
        .hold_hi_q  (hold_hi_q),
        .ctrl_wr    (ctrl_wr),
        .hi_wr      (hi_wr),
        .bus_rdata  (bus_rdata)
    );

    dac_trig_unit #(.NUM_TRIG(NUM_TRIG)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .flag_clr (flag_clr),
        .sel      (ctrl_q[SEL_LSB +: SEL_W]),
        .rise     (rise_vec),
        .flags    (flag_vec),
        .sel_fire (sel_fire)
    );

    dac_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .new_en      (bus_wdata[BIT_EN]),
        .new_ate     (bus_wdata[BIT_ATE]),
        .hi_wr       (hi_wr),
        .sel_fire    (sel_fire),
        .mode_q      (mode),
        .load_direct (load_direct),
        .load_hold   (load_hold),
        .clear_code  (clear_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (clear_code) begin
            code_q <= '0;
        end else if (load_direct) begin
            code_q <= pack_code(ctrl_q[BIT_LADJ], bus_wdata, lo_stage_q);
        end else if (load_hold) begin
            code_q <= pack_code(ctrl_q[BIT_LADJ], hold_hi_q, hold_lo_q);
        end
    end

    assign dac_code = (mode == MODE_OFF) ? '0 : code_q;
    assign dac_en   = ctrl_q[BIT_EN];
    assign dac_oe   = ctrl_q[BIT_OE];

endmodule

// File: rtl/dac_update_ctrl_chk.sv
module dac_update_ctrl_chk #(
    parameter int unsigned NUM_TRIG = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [1:0]          bus_addr,
    input logic [7:0]          bus_wdata,
    input logic [7:0]          bus_rdata,
    input logic [7:0]          ctrl_q,
    input logic [NUM_TRIG-1:0] rise_vec,
    input logic [NUM_TRIG-1:0] flag_vec,
    input logic [9:0]          dac_code,
    input logic                dac_en
);

    logic       ate;
    logic       ladj;
    logic [2:0] sel;
    logic       hi_wr;

    assign ate   = ctrl_q[7];
    assign ladj  = ctrl_q[2];
    assign sel   = ctrl_q[6:4];
    assign hi_wr = bus_we && (bus_addr == 2'd2);

    AST_RSVD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[3] == 1'b0)); // R2

    AST_OFF_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_en |-> (dac_code == 10'd0)); // R10

    AST_DIRECT_HI_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_en && !ate && !ladj && hi_wr) |=> (dac_code[9:8] == $past(bus_wdata[1:0]))); // R4

    AST_UPDATE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_en && $past(dac_en) && !$stable(dac_code))
            |-> ($past(hi_wr && !ate) || $past(ate && rise_vec[sel]))); // R7

    AST_FLAG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_en && ate && rise_vec[sel] && flag_vec[sel] && !(bus_we && bus_addr == 2'd0))
            |=> $stable(dac_code)); // R9

    AST_LOW_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_en && bus_we && bus_addr == 2'd1 && rise_vec == '0) |=> $stable(dac_code)); // R5

endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(.NUM_TRIG(NUM_TRIG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_q),
    .rise_vec  (rise_vec),
    .flag_vec  (flag_vec),
    .dac_code  (dac_code),
    .dac_en    (dac_en)
);

// File: tb/sim_dac_update_ctrl.sv
`timescale 1ns/1ps
module sim_dac_update_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] trig_in = 8'd0;
    logic [7:0] flag_clr = 8'd0;
    logic [9:0] dac_code;
    logic       dac_en;
    logic       dac_oe;

    int n_checks = 0;
    int n_fail = 0;

    // Behavioural reference state
    logic [7:0] m_ctrl = 0, m_lo = 0, m_hlo = 0, m_hhi = 0, m_flags = 0, m_prev = 0;
    logic [9:0] m_code = 0;
    bit compare_on = 0;

    always #10 clk = ~clk;

    dac_update_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .trig_in   (trig_in),
        .flag_clr  (flag_clr),
        .dac_code  (dac_code),
        .dac_en    (dac_en),
        .dac_oe    (dac_oe)
    );

    function automatic logic [9:0] form(input logic l, input logic [7:0] hi, input logic [7:0] lo);
        return l ? {hi, lo[7:6]} : {hi[1:0], lo};
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            logic [7:0] r;
            int s;
            r = trig_in & ~m_prev;
            s = int'(m_ctrl[6:4]);
            if (!m_ctrl[0]) begin
                m_code = 0;
            end else if (!m_ctrl[7] && bus_we && bus_addr == 2) begin
                m_code = form(m_ctrl[2], bus_wdata, m_lo);
            end else if (m_ctrl[7] && r[s] && !m_flags[s]) begin
                m_code = form(m_ctrl[2], m_hhi, m_hlo);
            end
            m_flags = (m_flags & ~flag_clr) | r;
            m_prev = trig_in;
            if (bus_we && bus_addr == 0) m_ctrl = bus_wdata & 8'hF7;
            if (bus_we && bus_addr == 1) m_lo = bus_wdata;
            if (bus_we && bus_addr == 2) begin
                m_hhi = bus_wdata;
                m_hlo = m_lo;
            end
        end
    end

    always @(negedge clk) begin
        if (compare_on) begin
            n_checks++;
            if (dac_code !== (m_ctrl[0] ? m_code : 10'd0) || dac_en !== m_ctrl[0] || dac_oe !== m_ctrl[1]) begin
                n_fail++;
                $display("FAIL model compare (R3,R4,R7,R9,R10): code=%h en=%b oe=%b expected code=%h en=%b oe=%b",
                         dac_code, dac_en, dac_oe, m_ctrl[0] ? m_code : 10'd0, m_ctrl[0], m_ctrl[1]);
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        trig_in[i] = 1'b1;
        @(negedge clk);
        trig_in[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr(input int i);
        @(negedge clk);
        flag_clr[i] = 1'b1;
        @(negedge clk);
        flag_clr[i] = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_on = 1;

        // R1 reset state
        rd(2'd0, d);
        check("R1 ctrl", 16'(d), 16'h00);
        check("R1 code", 16'(dac_code), 16'h000);
        check("R1 en/oe", 16'({dac_en, dac_oe}), 16'h0);

        // R2 readback with bit 3 forced to zero; R3 enable pins
        wr(2'd0, 8'hFF);
        rd(2'd0, d);
        check("R2 ctrl readback", 16'(d), 16'hF7);
        check("R3 en/oe", 16'({dac_en, dac_oe}), 16'h3);
        wr(2'd0, 8'h03);

        // R5 low write alone; R4 direct update right-aligned
        wr(2'd1, 8'h5A);
        check("R5 low write no change", 16'(dac_code), 16'h000);
        rd(2'd1, d);
        check("R2 low readback", 16'(d), 16'h5A);
        wr(2'd2, 8'h03);
        check("R4 direct update", 16'(dac_code), 16'h35A);
        wr(2'd1, 8'h11);
        check("R5 low write held", 16'(dac_code), 16'h35A);

        // R6 left adjust
        wr(2'd0, 8'h07);
        wr(2'd1, 8'h80);
        wr(2'd2, 8'hC3);
        check("R6 left adjust", 16'(dac_code), 16'h30E);

        // R8 trigger in direct mode
        pulse(2);
        check("R8 trigger in direct mode", 16'(dac_code), 16'h30E);
        clr(2);

        // R7 auto mode, select source 2, right aligned
        wr(2'd0, 8'hA3);
        wr(2'd1, 8'h22);
        wr(2'd2, 8'h01);
        check("R7 high write in auto", 16'(dac_code), 16'h30E);
        pulse(5);
        check("R8 unselected trigger", 16'(dac_code), 16'h30E);
        pulse(2);
        check("R7 selected edge", 16'(dac_code), 16'h122);

        // R9 flag still set blocks; clear releases
        wr(2'd1, 8'h33);
        wr(2'd2, 8'h02);
        pulse(2);
        check("R9 flag blocks", 16'(dac_code), 16'h122);
        clr(2);
        pulse(2);
        check("R9 after clear", 16'(dac_code), 16'h233);

        // R7 level held high does not update twice
        clr(2);
        wr(2'd1, 8'h44);
        wr(2'd2, 8'h00);
        @(negedge clk);
        trig_in[2] = 1'b1;
        @(negedge clk);
        check("R7 rising edge", 16'(dac_code), 16'h044);
        wr(2'd1, 8'h55);
        wr(2'd2, 8'h01);
        clr(2);
        repeat (3) @(negedge clk);
        check("R7 level held", 16'(dac_code), 16'h044);
        trig_in[2] = 1'b0;

        // R10 disabled
        wr(2'd0, 8'hA2);
        check("R10 code zero", 16'(dac_code), 16'h000);
        clr(2);
        pulse(2);
        wr(2'd2, 8'h03);
        check("R10 no update", 16'(dac_code), 16'h000);
        check("R3 en off", 16'({dac_en, dac_oe}), 16'h1);

        repeat (2) @(negedge clk);
        compare_on = 0;
        finish_run();
    end

endmodule